// File: doc/BRIEF.md
# Oversampled Asynchronous Byte Receiver

This block receives asynchronous serial characters of ten bits: a low start bit, eight data bits sent least-significant first, and a stop bit. It runs from the system clock and advances its bit timing only on a one-cycle enable pulse that arrives sixteen times per bit period. The serial input passes through a two-flop synchronizer. A falling edge on the synchronized line restarts the internal sixteen-count timer, so the timer lines up with the incoming start bit.

The start bit must still read low eight counts after the edge. If it does not, the edge is treated as noise and the receiver goes back to waiting for the next falling edge. After a confirmed start, each further bit is sampled sixteen counts after the previous sample, which is the middle of that bit. After the stop bit has been sampled, the receiver rearms.

A completed character is committed only when the done flag is clear, and, in multiprocessor mode, only when its stop bit reads 1. A commit stores the byte and the stop bit and raises the done flag. A character that fails either condition is discarded, and the previously stored values remain on the outputs. Software lowers the flag with a one-cycle clear pulse.

Top module: `async_byte_rx`

## Requirements
- R1: After reset, `rx_done`, `rx_byte` and `rx_stop` are all 0.
- R2: A falling edge whose line is back high at the eighth tick after the edge produces no character: `rx_done`, `rx_byte` and `rx_stop` keep their values.
- R3: Data bits are sampled at mid-bit, one every sixteen ticks after the start-bit check. The first data bit received lands in `rx_byte[0]`.
- R4: A committed character raises `rx_done` and loads `rx_byte` with the data and `rx_stop` with the sampled stop-bit level.
- R5: While `rx_done` is 1, an arriving character is discarded. `rx_byte` and `rx_stop` keep their values and `rx_done` stays 1 until it is cleared.
- R6: With `mp_mode` = 1, a character whose stop bit is 0 is discarded and the outputs keep their values. With `mp_mode` = 1 and stop bit 1, the character is committed.
- R7: With `mp_mode` = 0, a character whose stop bit is 0 is still committed, and `rx_stop` reads 0.
- R8: After the stop-bit sample, or after a rejected start, the receiver rearms. The next falling edge starts a new character that is received correctly.
- R9: A pulse on `rx_done_clr` makes `rx_done` read 0 in the next cycle. A clear pulse takes priority over a commit in the same cycle.
- R10: `rx_byte` and `rx_stop` change only in the cycle in which `rx_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_x16 | input | 1 | One-cycle enable pulse, sixteen per bit period |
| line_in | input | 1 | Asynchronous serial input; idles high |
| rx_done_clr | input | 1 | One-cycle pulse that clears the done flag |
| mp_mode | input | 1 | Multiprocessor mode: when 1, only characters with stop bit 1 are committed |
| rx_done | output | 1 | Done flag: a character has been committed |
| rx_byte | output | 8 | Byte from the last committed character |
| rx_stop | output | 1 | Stop-bit level from the last committed character |

## Verification
The properties assume the following about the inputs:
- `rx_done_clr` is a short pulse.
- `mp_mode` holds steady while a character is in flight, because the commit decision reads it in the cycle the frame completes.
- `tick_x16` is a single-cycle pulse.

The stimulus drives ticks at a fixed spacing of four clocks. It changes `mp_mode` only during idle gaps, and it issues clear pulses only after a character has been committed and well before the next stop bit. Every bit is held for exactly sixteen ticks. The noise pulse stays low for fewer than eight ticks, so the start check sees the line high again.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    // Bits [STAGES-1:0] form the synchronizer chain.
    // Bit [STAGES] holds the previous synchronized value for edge detection.
    localparam int W = STAGES + 1;

    logic [W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[W-2:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign line_s = pipe_q[STAGES-1];
    assign fall   = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_s,
    input  logic                 fall,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_stop
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int IDX_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID_CNT  = OSR / 2 - 1;
    localparam int LAST_CNT = OSR - 1;

    typedef struct packed {
        rx_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 done;
        logic                 stop;
    } core_t;

    core_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (fall) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(MID_CNT)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = line_s ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(LAST_CNT)) begin
                        d.cnt   = '0;
                        d.shreg = {line_s, q.shreg[DATA_BITS-1:1]};
                        if (q.idx == IDX_W'(DATA_BITS - 1)) d.st = ST_STOP;
                        else                                d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(LAST_CNT)) begin
                        d.cnt  = '0;
                        d.stop = line_s;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, idx: '0, shreg: '0, done: 1'b0, stop: 1'b0};
        else        q <= d;
    end

    assign frame_done = q.done;
    assign frame_data = q.shreg;
    assign frame_stop = q.stop;
endmodule

// File: rtl/rx_accept_gate.sv
module rx_accept_gate #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 frame_stop,
    input  logic                 mp_mode,
    input  logic                 clr,
    output logic                 flag,
    output logic [DATA_BITS-1:0] data,
    output logic                 stop
);
    typedef struct packed {
        logic                 flag;
        logic [DATA_BITS-1:0] data;
        logic                 stop;
    } acc_t;

    acc_t q, d;
    logic take;

    always_comb begin
        d    = q;
        // Commit only when the flag is clear, no clear is pending, and the
        // multiprocessor condition is met.
        take = frame_done && !q.flag && !clr && (!mp_mode || frame_stop);
        if (clr) d.flag = 1'b0;
        if (take) begin
            d.flag = 1'b1;
            d.data = frame_data;
            d.stop = frame_stop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;
    assign data = q.data;
    assign stop = q.stop;
endmodule

// File: rtl/async_byte_rx.sv
module async_byte_rx #(
    parameter int OSR         = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_x16,
    input  logic                 line_in,
    input  logic                 rx_done_clr,
    input  logic                 mp_mode,
    output logic                 rx_done,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_stop
);
    logic                 line_s;
    logic                 fall;
    logic                 frame_done;
    logic [DATA_BITS-1:0] frame_data;
    logic                 frame_stop;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    rx_frame_fsm #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_x16),
        .line_s    (line_s),
        .fall      (fall),
        .frame_done(frame_done),
        .frame_data(frame_data),
        .frame_stop(frame_stop)
    );

    rx_accept_gate #(.DATA_BITS(DATA_BITS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .frame_data(frame_data),
        .frame_stop(frame_stop),
        .mp_mode   (mp_mode),
        .clr       (rx_done_clr),
        .flag      (rx_done),
        .data      (rx_byte),
        .stop      (rx_stop)
    );
endmodule

// File: rtl/async_byte_rx_checks.sv
module async_byte_rx_checks #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 mp_mode,
    input logic                 frame_done,
    input logic                 rx_done,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 rx_stop
);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rx_done);

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr) |=> rx_done);

    p_out_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_done) |-> ($stable(rx_byte) && $stable(rx_stop)));

    p_rise_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frame_done));

    p_mp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(mp_mode)) |-> rx_stop);
endmodule

bind async_byte_rx async_byte_rx_checks #(.DATA_BITS(DATA_BITS)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_done_clr),
    .mp_mode   (mp_mode),
    .frame_done(frame_done),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .rx_stop   (rx_stop)
);

// File: tb/tb_async_byte_rx.sv
module tb_async_byte_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int BIT_CLKS   = OSR * TICK_DIV;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_x16 = 1'b0;
    logic       line_in = 1'b1;
    logic       rx_done_clr = 1'b0;
    logic       mp_mode = 1'b0;
    logic       rx_done;
    logic [7:0] rx_byte;
    logic       rx_stop;

    int n_total = 0;
    int n_bad   = 0;

    // Reference state kept from the requirements.
    logic [8:0] exp_q[$];
    logic       exp_flag = 1'b0;
    logic [7:0] exp_byte = 8'h00;
    logic       exp_stop = 1'b0;
    logic       prev_done = 1'b0;
    int         tick_cnt = 0;

    async_byte_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_x16   (tick_x16),
        .line_in    (line_in),
        .rx_done_clr(rx_done_clr),
        .mp_mode    (mp_mode),
        .rx_done    (rx_done),
        .rx_byte    (rx_byte),
        .rx_stop    (rx_stop)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Generate one tick every TICK_DIV clocks.
    always @(negedge clk) begin
        tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick_x16 <= (tick_cnt == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: on each rise of rx_done, pop the next expected character and compare.
    always @(negedge clk) begin
        if (rst_n && rx_done && !prev_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected commit", 1, 0);
            end else begin
                logic [8:0] it;
                it = exp_q.pop_front();
                check(rx_byte == it[7:0], "R3", "byte lsb first", rx_byte, it[7:0]);
                check(rx_stop == it[8], "R4", "stop bit captured", rx_stop, it[8]);
            end
        end
        prev_done = rx_done;
    end

    task automatic hold_bit(input logic v);
        line_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic s, input string req);
        logic accept;
        accept = !exp_flag && (!mp_mode || s);
        if (accept) begin
            exp_q.push_back({s, b});
            exp_flag = 1'b1;
            exp_byte = b;
            exp_stop = s;
        end
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit(s);
        hold_bit(1'b1);
        check(rx_done == exp_flag, req, "done flag after frame", rx_done, exp_flag);
        check(rx_byte == exp_byte, req, "byte after frame", rx_byte, exp_byte);
        check(rx_stop == exp_stop, req, "stop after frame", rx_stop, exp_stop);
        check(exp_q.size() == 0, req, "pending expected items", exp_q.size(), 0);
    endtask

    task automatic clear_flag();
        rx_done_clr = 1'b1;
        @(negedge clk);
        rx_done_clr = 1'b0;
        exp_flag = 1'b0;
        check(rx_done == 1'b0, "R9", "flag after clear", rx_done, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(rx_done == 1'b0, "R1", "reset done", rx_done, 0);
        check(rx_byte == 8'h00, "R1", "reset byte", rx_byte, 0);
        check(rx_stop == 1'b0, "R1", "reset stop", rx_stop, 0);
        rst_n = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R3 / R4: several data patterns
        send_frame(8'hA5, 1'b1, "R4"); clear_flag();
        send_frame(8'h3C, 1'b1, "R3"); clear_flag();
        send_frame(8'h00, 1'b1, "R3"); clear_flag();
        send_frame(8'hFF, 1'b1, "R3"); clear_flag();
        send_frame(8'h01, 1'b1, "R3"); clear_flag();

        // R2: short noise pulse (3 ticks low), then the line is high again
        line_in = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        line_in = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        check(rx_done == 1'b0, "R2", "done after noise", rx_done, 0);
        check(rx_byte == exp_byte, "R2", "byte after noise", rx_byte, exp_byte);
        check(rx_stop == exp_stop, "R2", "stop after noise", rx_stop, exp_stop);

        // R8: a valid character right after the rejected start
        send_frame(8'h5A, 1'b1, "R8"); clear_flag();

        // R5: flag left set, the next character is dropped
        send_frame(8'h66, 1'b1, "R4");
        send_frame(8'h99, 1'b1, "R5");
        clear_flag();

        // R6: multiprocessor mode
        mp_mode = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(8'h77, 1'b0, "R6");
        send_frame(8'hC3, 1'b1, "R6"); clear_flag();
        mp_mode = 1'b0;
        repeat (4) @(negedge clk);

        // R7: stop bit 0 still accepted outside multiprocessor mode
        send_frame(8'h18, 1'b0, "R7"); clear_flag();
        // R8: rearm after a low stop bit
        send_frame(8'h81, 1'b1, "R8"); clear_flag();

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule